// File: doc/BRIEF.md
# Partitioned Integer Lane ALU

This block is one 64-bit slice of a vector arithmetic unit. At run time it treats the 64-bit element either as one 64-bit value or as two, four or eight independent sub-elements of 32, 16 or 8 bits. On each sub-element it performs add, subtract, shift left, shift right with rounding, bitwise logic or multiply-add. Saturation to the sub-element's signed or unsigned range is optional. When it is on, a status bit reports each sub-element that was clamped. Carries and shifted bits never cross from one sub-element into the next, so four such slices can work side by side on a 256-bit vector without talking to each other.

The second operand can come from the vector inputs or from a scalar that is broadcast to every sub-element, and the scalar can sit on either side of the operation. A per-element flag bit travels with the operation. When the flag is clear, the result is not written back, which gives conditional execution. Operations enter with a valid strobe and leave two clock edges later through a fixed two-stage pipeline. A new operation can be issued every cycle.

Top module: `laneAlu`

## Requirements
- R1: `widthSel` selects the sub-element width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Sub-element i occupies bits [i*W +: W], and no carry, borrow or shifted bit crosses a sub-element boundary.
- R2: `opSel` 0 is add and 1 is subtract. With `satEn` low, the result is the low W bits of the exact result (wrap-around).
- R3: With `satEn` high, results of add, subtract, shift and multiply-add are clamped. With `signedOp` high, out-of-range results become 2^(W-1)-1 or -2^(W-1). With `signedOp` low, they become 2^W-1 or 0.
- R4: `outSat` bit i is set exactly when sub-element i was clamped. Bits at or above the sub-element count are 0, and all bits are 0 when `outWe` is low.
- R5: `opSel` 2 shifts left and `opSel` 3 shifts right. The shift amount is the low log2(W) bits of the second operand's sub-element. A right shift fills with the sign bit when `signedOp` is high and with zeros when it is low.
- R6: On a right shift, `roundSel` 0 truncates, 1 rounds half up (adds the last bit shifted out) and 2 rounds to nearest with ties going to the even value. Code 3 acts as truncate.
- R7: `opSel` 7 computes first*second + `vecAcc` per sub-element, with the sign taken from `signedOp`. It wraps or clamps as R2 and R3 describe.
- R8: `opSel` 4, 5 and 6 give the bitwise AND, OR and XOR of the operands. They never saturate.
- R9: `formSel` 0 (and 3) uses `vecA` and `vecB`. Form 1 uses `vecA` and the low W bits of `scalarIn`. Form 2 uses the scalar as the first operand and `vecA` as the second. The scalar value is broadcast to every sub-element.
- R10: `outWe` equals the `inMask` bit of the operation issued two cycles earlier, qualified by its valid. `outValid` does not depend on the mask.
- R11: `outValid` follows `inValid` after two rising edges. During reset `outValid`, `outWe` and `outSat` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation present this cycle |
| inMask | input | 1 | Element flag; when 0 the result is not written |
| opSel | input | 3 | Operation code |
| widthSel | input | 2 | Sub-element width mode |
| formSel | input | 2 | Operand form (vector-vector, vector-scalar, scalar-vector) |
| signedOp | input | 1 | Signed interpretation of sub-elements |
| satEn | input | 1 | Enable saturation |
| roundSel | input | 2 | Rounding mode for right shifts |
| vecA | input | 64 | First vector operand |
| vecB | input | 64 | Second vector operand |
| vecAcc | input | 64 | Addend for multiply-add |
| scalarIn | input | 64 | Scalar operand (low sub-element used) |
| outValid | output | 1 | Result present |
| outWe | output | 1 | Write enable of the result |
| outData | output | 64 | Result element |
| outSat | output | 8 | Per-sub-element saturation status |

## Verification
The bound assertions check, on every cycle, the relations that hold at the ports:
- the two-edge timing of `outValid` and `outWe` relative to `inValid` and `inMask`;
- that status bits appear only on written results;
- that status bits stay inside the active sub-element count for the width mode;
- that logic operations, and operations with saturation off, never raise a status bit.

The arithmetic values themselves only the bench scenarios can show: boundary carries in each width mode, clamping at both signed and unsigned limits, each rounding mode on exact ties, multiply-add overflow and operand order in the scalar forms. These are compared against a sub-element model computed in the bench.

// File: rtl/laneAluPkg.sv
package laneAluPkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_SHL  = 3'd2,
    OP_SHR  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_MADD = 3'd7
  } opCodeT;

  typedef enum logic [1:0] {
    RND_TRUNC   = 2'd0,
    RND_HALF_UP = 2'd1,
    RND_EVEN    = 2'd2
  } roundT;

  // strobes for a sub-element arithmetic unit
  typedef struct packed {
    logic       doAdd;
    logic       doSub;
    logic       doShl;
    logic       doShr;
    logic       doMul;
    logic       doLogic;
    logic [1:0] logicSel;   // 0 and, 1 or, 2 xor
    logic       signedOp;
    logic       clampEn;
    logic [1:0] roundSel;
  } opCtlT;

  // strobes from control to datapath
  typedef struct packed {
    opCtlT op;
    logic  useScalarA;
    logic  useScalarB;
  } dpCtlT;

endpackage

// File: rtl/laneSubAlu.sv
module laneSubAlu
  import laneAluPkg::*;
#(
  parameter int W = 8
) (
  input  opCtlT        ctl,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] r,
  output logic         sat
);
  localparam int WW   = 2 * W + 2;
  localparam int SH_W = $clog2(W);
  localparam logic signed [WW-1:0] ONE_W = 1;
  localparam logic signed [WW-1:0] MAX_S = (ONE_W <<< (W - 1)) - ONE_W;
  localparam logic signed [WW-1:0] MIN_S = -(ONE_W <<< (W - 1));
  localparam logic signed [WW-1:0] MAX_U = (ONE_W <<< W) - ONE_W;

  logic signed [WW-1:0] xe, ye, ze, shrVal, wide, hiLim, loLim;
  logic [SH_W-1:0] shAmt, shAmtM1;
  logic [W-1:0]    lowMask;
  logic            halfBit, stickyBit, rndInc;

  always_comb begin
    xe = ctl.signedOp ? {{(WW-W){x[W-1]}}, x} : {{(WW-W){1'b0}}, x};
    ye = ctl.signedOp ? {{(WW-W){y[W-1]}}, y} : {{(WW-W){1'b0}}, y};
    ze = ctl.signedOp ? {{(WW-W){z[W-1]}}, z} : {{(WW-W){1'b0}}, z};

    shAmt   = y[SH_W-1:0];
    shAmtM1 = shAmt - 1'b1;
    shrVal  = xe >>> shAmt;
    lowMask = (W'(1) << shAmtM1) - W'(1);
    halfBit   = (shAmt != '0) && x[shAmtM1];
    stickyBit = (shAmt > SH_W'(1)) && (|(x & lowMask));
    case (roundT'(ctl.roundSel))
      RND_HALF_UP: rndInc = halfBit;
      RND_EVEN:    rndInc = halfBit && (stickyBit || shrVal[0]);
      default:     rndInc = 1'b0;
    endcase

    if (ctl.doAdd)      wide = xe + ye;
    else if (ctl.doSub) wide = xe - ye;
    else if (ctl.doShl) wide = xe <<< shAmt;
    else if (ctl.doShr) wide = shrVal + $signed({{(WW-1){1'b0}}, rndInc});
    else if (ctl.doMul) wide = xe * ye + ze;
    else                wide = '0;

    hiLim = ctl.signedOp ? MAX_S : MAX_U;
    loLim = ctl.signedOp ? MIN_S : '0;
    sat   = 1'b0;
    r     = wide[W-1:0];
    if (ctl.doLogic) begin
      case (ctl.logicSel)
        2'd0:    r = x & y;
        2'd1:    r = x | y;
        default: r = x ^ y;
      endcase
    end else if (ctl.clampEn && (wide > hiLim)) begin
      r   = hiLim[W-1:0];
      sat = 1'b1;
    end else if (ctl.clampEn && (wide < loLim)) begin
      r   = loLim[W-1:0];
      sat = 1'b1;
    end
  end
endmodule

// File: rtl/laneAluCtrl.sv
module laneAluCtrl
  import laneAluPkg::*;
#(
  parameter int WSEL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inMask,
  input  logic [2:0]        opSel,
  input  logic [WSEL_W-1:0] widthSel,
  input  logic [1:0]        formSel,
  input  logic              signedOp,
  input  logic              satEn,
  input  logic [1:0]        roundSel,
  output dpCtlT             dpCtl,
  output logic [WSEL_W-1:0] widthSel1,
  output logic              outValid,
  output logic              outWe
);
  dpCtlT dpNext;
  logic  valid1, mask1;

  always_comb begin
    dpNext = '0;
    case (opCodeT'(opSel))
      OP_ADD:  dpNext.op.doAdd = 1'b1;
      OP_SUB:  dpNext.op.doSub = 1'b1;
      OP_SHL:  dpNext.op.doShl = 1'b1;
      OP_SHR:  dpNext.op.doShr = 1'b1;
      OP_AND:  begin dpNext.op.doLogic = 1'b1; dpNext.op.logicSel = 2'd0; end
      OP_OR:   begin dpNext.op.doLogic = 1'b1; dpNext.op.logicSel = 2'd1; end
      OP_XOR:  begin dpNext.op.doLogic = 1'b1; dpNext.op.logicSel = 2'd2; end
      default: dpNext.op.doMul = 1'b1;
    endcase
    dpNext.op.signedOp = signedOp;
    dpNext.op.roundSel = roundSel;
    dpNext.op.clampEn  = satEn && !dpNext.op.doLogic;
    dpNext.useScalarB  = (formSel == 2'd1);
    dpNext.useScalarA  = (formSel == 2'd2);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dpCtl     <= '0;
      widthSel1 <= '0;
      valid1    <= 1'b0;
      mask1     <= 1'b0;
      outValid  <= 1'b0;
      outWe     <= 1'b0;
    end else begin
      dpCtl     <= dpNext;
      widthSel1 <= widthSel;
      valid1    <= inValid;
      mask1     <= inMask;
      outValid  <= valid1;
      outWe     <= valid1 && mask1;
    end
  end
endmodule

// File: rtl/laneAluDatapath.sv
module laneAluDatapath
  import laneAluPkg::*;
#(
  parameter int LANE_W    = 64,
  parameter int NUM_MODES = 4,
  parameter int WSEL_W    = 2,
  parameter int SAT_W     = 8
) (
  input  logic              clk,
  input  dpCtlT             dpCtl,
  input  logic [WSEL_W-1:0] widthSel1,
  input  logic [LANE_W-1:0] vecA,
  input  logic [LANE_W-1:0] vecB,
  input  logic [LANE_W-1:0] vecAcc,
  input  logic [LANE_W-1:0] scalarIn,
  output logic [LANE_W-1:0] resData,
  output logic [SAT_W-1:0]  resSat
);
  logic [LANE_W-1:0] opA1, opB1, opC1, opS1;
  logic [LANE_W-1:0] resByMode [NUM_MODES];
  logic [SAT_W-1:0]  satByMode [NUM_MODES];
  logic [LANE_W-1:0] resNext;
  logic [SAT_W-1:0]  satNext;

  always_ff @(posedge clk) begin
    opA1 <= vecA;
    opB1 <= vecB;
    opC1 <= vecAcc;
    opS1 <= scalarIn;
  end

  for (genvar g = 0; g < NUM_MODES; g++) begin : gMode
    localparam int W = 8 << g;
    localparam int N = LANE_W / W;
    logic [LANE_W-1:0] modeRes;
    logic [SAT_W-1:0]  modeSat;
    for (genvar i = 0; i < N; i++) begin : gElem
      logic [W-1:0] aS, bS, sS, xS, yS, rS;
      logic         satS;
      assign aS = opA1[i*W +: W];
      assign bS = opB1[i*W +: W];
      assign sS = opS1[W-1:0];
      assign xS = dpCtl.useScalarA ? sS : aS;
      assign yS = dpCtl.useScalarB ? sS : (dpCtl.useScalarA ? aS : bS);
      laneSubAlu #(.W(W)) uSub (
        .ctl(dpCtl.op), .x(xS), .y(yS), .z(opC1[i*W +: W]), .r(rS), .sat(satS)
      );
      assign modeRes[i*W +: W] = rS;
      assign modeSat[i]        = satS;
    end
    if (N < SAT_W) begin : gSatPad
      assign modeSat[SAT_W-1:N] = '0;
    end
    assign resByMode[g] = modeRes;
    assign satByMode[g] = modeSat;
  end

  always_comb begin
    resNext = resByMode[0];
    satNext = satByMode[0];
    for (int m = 1; m < NUM_MODES; m++) begin
      if (int'(widthSel1) == m) begin
        resNext = resByMode[m];
        satNext = satByMode[m];
      end
    end
  end

  always_ff @(posedge clk) begin
    resData <= resNext;
    resSat  <= satNext;
  end
endmodule

// File: rtl/laneAlu.sv
module laneAlu
  import laneAluPkg::*;
#(
  parameter int LANE_W    = 64,
  parameter int NUM_MODES = $clog2(LANE_W / 8) + 1,
  parameter int WSEL_W    = $clog2(NUM_MODES),
  parameter int SAT_W     = LANE_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inMask,
  input  logic [2:0]        opSel,
  input  logic [WSEL_W-1:0] widthSel,
  input  logic [1:0]        formSel,
  input  logic              signedOp,
  input  logic              satEn,
  input  logic [1:0]        roundSel,
  input  logic [LANE_W-1:0] vecA,
  input  logic [LANE_W-1:0] vecB,
  input  logic [LANE_W-1:0] vecAcc,
  input  logic [LANE_W-1:0] scalarIn,
  output logic              outValid,
  output logic              outWe,
  output logic [LANE_W-1:0] outData,
  output logic [SAT_W-1:0]  outSat
);
  dpCtlT             dpCtl;
  logic [WSEL_W-1:0] widthSel1;
  logic [SAT_W-1:0]  resSat;

  laneAluCtrl #(.WSEL_W(WSEL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inMask(inMask), .opSel(opSel),
    .widthSel(widthSel), .formSel(formSel), .signedOp(signedOp), .satEn(satEn),
    .roundSel(roundSel), .dpCtl(dpCtl), .widthSel1(widthSel1),
    .outValid(outValid), .outWe(outWe)
  );

  laneAluDatapath #(
    .LANE_W(LANE_W), .NUM_MODES(NUM_MODES), .WSEL_W(WSEL_W), .SAT_W(SAT_W)
  ) uDp (
    .clk(clk), .dpCtl(dpCtl), .widthSel1(widthSel1), .vecA(vecA), .vecB(vecB),
    .vecAcc(vecAcc), .scalarIn(scalarIn), .resData(outData), .resSat(resSat)
  );

  assign outSat = resSat & {SAT_W{outWe}};
endmodule

// File: rtl/laneAluChecker.sv
module laneAluChecker #(
  parameter int LANE_W    = 64,
  parameter int NUM_MODES = $clog2(LANE_W / 8) + 1,
  parameter int WSEL_W    = $clog2(NUM_MODES),
  parameter int SAT_W     = LANE_W / 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inMask,
  input logic [2:0]        opSel,
  input logic [WSEL_W-1:0] widthSel,
  input logic              satEn,
  input logic              outValid,
  input logic              outWe,
  input logic [SAT_W-1:0]  outSat
);
  logic [1:0] edgesOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               edgesOut <= 2'd0;
    else if (edgesOut != 2'd3) edgesOut <= edgesOut + 2'd1;
  end

  // R11: valid emerges two edges after issue
  assert_valid_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    (edgesOut >= 2'd2) |-> (outValid == $past(inValid, 2)));

  // R10: write enable follows the issued mask
  assert_we_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    (edgesOut >= 2'd2) |-> (outWe == $past(inValid && inMask, 2)));

  assert_we_needs_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    outWe |-> outValid);

  // R4: no status on unwritten results, none past the element count
  assert_sat_needs_we_R4: assert property (@(posedge clk) disable iff (!rstN)
    !outWe |-> (outSat == '0));

  assert_sat_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (edgesOut >= 2'd2 && outValid) |->
      ((outSat >> (SAT_W >> $past(widthSel, 2))) == '0));

  // R3: nothing clamps with saturation off
  assert_no_sat_when_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    (edgesOut >= 2'd2 && outValid && !$past(satEn, 2)) |-> (outSat == '0));

  // R8: logic operations never saturate
  assert_logic_no_sat_R8: assert property (@(posedge clk) disable iff (!rstN)
    (edgesOut >= 2'd2 && outValid && $past(opSel, 2) >= 3'd4 && $past(opSel, 2) <= 3'd6)
      |-> (outSat == '0));
endmodule

bind laneAlu laneAluChecker #(
  .LANE_W(LANE_W), .NUM_MODES(NUM_MODES), .WSEL_W(WSEL_W), .SAT_W(SAT_W)
) uChk (.*);

// File: tb/laneAlu_bench.sv
module laneAlu_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inMask = 1'b0, signedOp = 1'b0, satEn = 1'b0;
  logic [2:0] opSel = '0;
  logic [1:0] widthSel = '0, formSel = '0, roundSel = '0;
  logic [63:0] vecA = '0, vecB = '0, vecAcc = '0, scalarIn = '0;
  logic outValid, outWe;
  logic [63:0] outData;
  logic [7:0] outSat;

  int checks = 0;
  int errors = 0;

  bit e1Valid = 0, e1We = 0, e2Valid = 0, e2We = 0;
  logic [63:0] e1Data = '0, e2Data = '0;
  logic [7:0] e1Sat = '0, e2Sat = '0;
  string e1Tag = "", e2Tag = "";

  always #10 clk = ~clk;

  laneAlu u_laneAlu (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inMask(inMask), .opSel(opSel),
    .widthSel(widthSel), .formSel(formSel), .signedOp(signedOp), .satEn(satEn),
    .roundSel(roundSel), .vecA(vecA), .vecB(vecB), .vecAcc(vecAcc),
    .scalarIn(scalarIn), .outValid(outValid), .outWe(outWe), .outData(outData),
    .outSat(outSat)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic signed [129:0] toWide(input logic [63:0] u, input int w, input bit sgn);
    logic signed [129:0] t;
    logic signed [129:0] one1;
    one1 = 1;
    t = {66'd0, u};
    if (sgn && u[w-1]) t = t - (one1 <<< w);
    return t;
  endfunction

  function automatic void refCalc(input int op, input int wsel, input int form, input bit sgn,
      input bit sat, input int rnd, input logic [63:0] a, input logic [63:0] b,
      input logic [63:0] c, input logic [63:0] s, output logic [63:0] res, output logic [7:0] sv);
    int w;
    int n;
    logic [63:0] mk;
    logic signed [129:0] one1;
    one1 = 1;
    w = 8 << wsel;
    n = 64 / w;
    mk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    res = '0;
    sv = '0;
    for (int i = 0; i < n; i++) begin
      logic [63:0] ux, uy, uz, piece;
      logic signed [129:0] vx, vy, vz, v, q, rem, hw, hi, lo;
      int k;
      ux = (a >> (i * w)) & mk;
      uy = (b >> (i * w)) & mk;
      uz = (c >> (i * w)) & mk;
      if (form == 1) uy = s & mk;
      else if (form == 2) begin uy = ux; ux = s & mk; end
      vx = toWide(ux, w, sgn);
      vy = toWide(uy, w, sgn);
      vz = toWide(uz, w, sgn);
      k = int'(uy[5:0]) & (w - 1);
      v = '0;
      case (op)
        0: v = vx + vy;
        1: v = vx - vy;
        2: v = vx * (one1 <<< k);
        3: begin
          q = vx >>> k;
          rem = vx - (q <<< k);
          hw = (k > 0) ? (one1 <<< (k - 1)) : '0;
          if (k > 0 && rnd == 1 && rem >= hw) q = q + one1;
          if (k > 0 && rnd == 2 && (rem > hw || (rem == hw && q[0]))) q = q + one1;
          v = q;
        end
        7: v = vx * vy + vz;
        default: v = '0;
      endcase
      if (op >= 4 && op <= 6) begin
        piece = (op == 4) ? (ux & uy) : (op == 5) ? (ux | uy) : (ux ^ uy);
      end else begin
        hi = sgn ? ((one1 <<< (w - 1)) - one1) : ((one1 <<< w) - one1);
        lo = sgn ? -(one1 <<< (w - 1)) : '0;
        if (sat && v > hi) begin v = hi; sv[i] = 1'b1; end
        else if (sat && v < lo) begin v = lo; sv[i] = 1'b1; end
        piece = v[63:0] & mk;
      end
      res = res | (piece << (i * w));
    end
  endfunction

  task automatic checkOut();
    chk(outValid == e2Valid, "R11 outValid", 64'(outValid), 64'(e2Valid));
    if (e2Valid) begin
      chk(outWe == e2We, "R10 outWe", 64'(outWe), 64'(e2We));
      if (e2We) begin
        chk(outData == e2Data, {e2Tag, " data"}, outData, e2Data);
        chk(outSat == e2Sat, {"R4 sat ", e2Tag}, 64'(outSat), 64'(e2Sat));
      end else begin
        chk(outSat == 8'h00, "R10 masked sat", 64'(outSat), 64'h0);
      end
    end else begin
      chk(outWe == 1'b0, "R11 idle outWe", 64'(outWe), 64'h0);
    end
  endtask

  task automatic issue(input bit v, input bit m, input int op, input int wsel, input int form,
      input bit sgn, input bit sat, input int rnd, input logic [63:0] a, input logic [63:0] b,
      input logic [63:0] c, input logic [63:0] s, input string tag);
    logic [63:0] r;
    logic [7:0] sv;
    @(negedge clk);
    checkOut();
    e2Valid = e1Valid; e2We = e1We; e2Data = e1Data; e2Sat = e1Sat; e2Tag = e1Tag;
    inValid = v; inMask = m; opSel = 3'(op); widthSel = 2'(wsel); formSel = 2'(form);
    signedOp = sgn; satEn = sat; roundSel = 2'(rnd);
    vecA = a; vecB = b; vecAcc = c; scalarIn = s;
    refCalc(op, wsel, form, sgn, sat, rnd, a, b, c, s, r, sv);
    e1Valid = v; e1We = v && m; e1Data = r; e1Sat = sv; e1Tag = tag;
  endtask

  task automatic idle();
    issue(0, 0, 0, 0, 0, 0, 0, 0, '0, '0, '0, '0, "R11");
  endtask

  function automatic logic [63:0] randVec();
    case ($urandom % 6)
      0: return 64'h0;
      1: return '1;
      2: return 64'h8080_8080_8080_8080;
      3: return 64'h7F7F_7F7F_7F7F_7F7F;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  function automatic string tagFor(input int op, input bit sat, input int rnd);
    if (op <= 1) return sat ? "R3" : "R2";
    if (op == 2) return "R5";
    if (op == 3) return (rnd != 0) ? "R6" : "R5";
    if (op == 7) return "R7";
    return "R8";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R11 reset outValid", 64'(outValid), 64'h0);
    chk(outWe == 1'b0, "R11 reset outWe", 64'(outWe), 64'h0);
    chk(outSat == 8'h0, "R11 reset outSat", 64'(outSat), 64'h0);
    rstN = 1'b1;

    // R1: boundary carries in every width mode
    for (int ws = 0; ws < 4; ws++)
      issue(1, 1, 0, ws, 0, 0, 0, 0, 64'h00FF_7F80_FFFF_0001, 64'h0101_0101_0101_01FF, '0, '0, "R1");
    for (int ws = 0; ws < 4; ws++)
      issue(1, 1, 1, ws, 0, 0, 0, 0, 64'h0100_0000_8000_0000, 64'h0001_0001_0001_0001, '0, '0, "R1");
    // R2: wrap-around
    issue(1, 1, 1, 1, 0, 0, 0, 0, 64'h0, 64'h0001_0001_0001_0001, '0, '0, "R2");
    issue(1, 1, 0, 2, 0, 1, 0, 0, 64'h7FFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001, '0, '0, "R2");
    // R3: clamps, signed and unsigned, both directions
    issue(1, 1, 0, 0, 0, 1, 1, 0, 64'h7F7F_7F7F_0000_8080, 64'h0101_0101_0101_FFFF, '0, '0, "R3");
    issue(1, 1, 0, 0, 0, 0, 1, 0, 64'hFFFF_FFFF_0000_0000, 64'h0101_0101_0101_0101, '0, '0, "R3");
    issue(1, 1, 1, 0, 0, 0, 1, 0, 64'h0000_0000_0505_0505, 64'h0101_0101_0101_0303, '0, '0, "R3");
    issue(1, 1, 1, 1, 0, 1, 1, 0, 64'h8000_8000_7FFF_0000, 64'h0001_7FFF_FFFF_0001, '0, '0, "R3");
    issue(1, 1, 0, 3, 0, 1, 1, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, '0, '0, "R3");
    issue(1, 1, 1, 3, 0, 1, 1, 0, 64'h8000_0000_0000_0000, 64'h1, '0, '0, "R3");
    // R5: shifts stay inside sub-elements
    issue(1, 1, 2, 1, 0, 0, 0, 0, 64'h8001_4003_0001_FFFF, 64'h0001_0001_000F_0004, '0, '0, "R5");
    issue(1, 1, 3, 0, 0, 1, 0, 0, 64'h8080_7F7F_8001_FF40, 64'h0701_0703_0101_0206, '0, '0, "R5");
    issue(1, 1, 3, 0, 0, 0, 0, 0, 64'h8080_7F7F_8001_FF40, 64'h0701_0703_0101_0206, '0, '0, "R5");
    issue(1, 1, 2, 0, 0, 1, 1, 0, 64'h4020_C0E0_0101_7F81, 64'h0101_0101_0706_0101, '0, '0, "R5");
    // R6: rounding on exact ties and above ties
    for (int rm = 0; rm < 4; rm++) begin
      issue(1, 1, 3, 0, 0, 0, 0, rm, 64'h0305_0706_FBFD_0B0D, 64'h0101_0102_0101_0202, '0, '0, "R6");
      issue(1, 1, 3, 0, 0, 1, 0, rm, 64'h0305_0706_FBFD_0B0D, 64'h0101_0102_0101_0202, '0, '0, "R6");
      issue(1, 1, 3, 3, 0, 1, 0, rm, 64'hFFFF_FFFF_FFFF_FFFA, 64'h2, '0, '0, "R6");
    end
    // R7: multiply-add, wrap and clamp
    issue(1, 1, 7, 1, 0, 1, 1, 0, 64'h7FFF_8000_0003_FFFF, 64'h0002_0002_0004_FFFF, 64'h0000_0000_0005_0001, '0, "R7");
    issue(1, 1, 7, 1, 0, 0, 0, 0, 64'hFFFF_0100_0003_0010, 64'hFFFF_0100_0004_0010, 64'h0001_0000_0005_0000, '0, "R7");
    issue(1, 1, 7, 3, 0, 0, 1, 0, 64'hFFFF_FFFF_0000_0000, 64'h3, 64'h1, '0, "R7");
    issue(1, 1, 7, 0, 0, 0, 1, 0, 64'h1010_0102_0304_FF00, 64'h1010_0203_0405_0100, 64'h0001_0203_0405_0607, '0, "R7");
    // R8: logic, including saturation requested
    for (int lo = 4; lo <= 6; lo++)
      issue(1, 1, lo, 0, 0, 1, 1, 0, 64'hF0F0_1234_FFFF_0000, 64'hFF00_4321_0F0F_AAAA, '0, '0, "R8");
    // R9: operand forms; subtract shows operand order
    issue(1, 1, 1, 0, 1, 0, 0, 0, 64'h1011_1213_1415_1617, 64'h0, '0, 64'hAA05, "R9");
    issue(1, 1, 1, 0, 2, 0, 0, 0, 64'h0102_0304_0506_0708, 64'h0, '0, 64'hAA05, "R9");
    issue(1, 1, 1, 1, 3, 0, 0, 0, 64'h0102_0304_0506_0708, 64'h0001_0001_0001_0001, '0, 64'hFFFF, "R9");
    issue(1, 1, 0, 2, 1, 1, 1, 0, 64'h7FFF_FFF0_0000_0001, 64'h0, '0, 64'h1234_0000_0000_0010, "R9");
    // R10: masked element with clamping conditions, then unmasked
    issue(1, 0, 0, 0, 0, 1, 1, 0, 64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, '0, '0, "R10");
    issue(1, 1, 0, 0, 0, 1, 1, 0, 64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, '0, '0, "R10");
    // R11: gaps in the stream
    idle();
    issue(1, 1, 0, 2, 0, 0, 0, 0, 64'h5, 64'h6, '0, '0, "R11");
    idle();
    idle();

    for (int t = 0; t < 2500; t++) begin
      int op, ws, fm, rm;
      bit sg, st, vv, mm;
      op = int'($urandom % 8);
      ws = int'($urandom % 4);
      fm = int'($urandom % 4);
      rm = int'($urandom % 4);
      sg = 1'($urandom);
      st = 1'($urandom);
      vv = ($urandom % 10) != 0;
      mm = ($urandom % 7) != 0;
      issue(vv, mm, op, ws, fm, sg, st, rm, randVec(), randVec(), randVec(), randVec(),
            tagFor(op, st, rm));
    end

    idle();
    idle();
    idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule